// File: doc/BRIEF.md
# Double-Buffered ADC Sample Capture

This block sits between an ADC acquisition engine and a packet transmitter. The acquisition side delivers 16-bit conversion results one at a time, each tagged with a channel index. It also raises a pulse when it has finished a read sequence. Results go into a private working bank. The transmitter never sees that bank. It reads a second, published bank through a registered channel-select port.

The published bank changes only on a swap. A swap happens when the sequence-done pulse arrives and every channel selected by the enable mask has delivered a sample since the previous swap. All enabled channels are then copied in a single cycle. A reader therefore always receives a value from one complete conversion set. A 16-bit word never mixes bits from two conversions, and channels from different sets are never mixed either. The transmitter may read as fast as it likes. Until the next swap it keeps getting the last complete set.

Each swap raises a one-cycle pulse and sets a sticky flag. The flag stays set until the transmit side acknowledges it.

Top module: `adc_dbuf_capture`

## Requirements
- R1: After reset, every published channel reads as zero, `rd_data` is zero, and both `new_data_pulse` and `new_data_flag` are low.
- R2: A sample written with `acq_valid` goes to the working bank only. Reads of the published bank keep returning the previous value until a swap.
- R3: A swap takes place on a clock edge where `acq_seq_done` is high and every channel set in `ch_en_mask` has been written since the last swap. A write in that same cycle counts toward coverage and is included in the copy. A sequence-done pulse that arrives before coverage is complete is ignored.
- R4: A swap copies every enabled channel into the published bank at the same edge. For each channel, the newest sample written before or during the swap cycle is the one copied.
- R5: Channels that are not enabled do not count toward coverage, and their published values are not changed by a swap. When the mask is all zero, no swap ever occurs.
- R6: On an edge where `rd_en` is high, `rd_data` captures the published value of channel `rd_ch`. The value is visible from just after that edge. While `rd_en` is low, `rd_data` holds its value.
- R7: When a read and a swap happen at the same edge, the read returns the value from before the swap.
- R8: `new_data_pulse` is high for exactly the one cycle that follows each swap edge, and is low at all other times.
- R9: `new_data_flag` sets on a swap and stays set until an edge where `new_data_ack` is high. If a swap and an acknowledge happen at the same edge, the flag stays set.
- R10: After a swap, channel coverage starts again from empty. The next swap needs a fresh write to every enabled channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en_mask | input | NUM_CH | Channels that take part in the sequence |
| acq_valid | input | 1 | Sample strobe from the acquisition side |
| acq_ch | input | IDX_W | Channel index of the sample |
| acq_data | input | SAMPLE_W | Conversion result |
| acq_seq_done | input | 1 | End-of-sequence pulse |
| rd_en | input | 1 | Read strobe from the transmit side |
| rd_ch | input | IDX_W | Channel selected for reading |
| rd_data | output | SAMPLE_W | Registered published sample |
| new_data_ack | input | 1 | Clears the sticky new-data flag |
| new_data_pulse | output | 1 | One-cycle pulse after each swap |
| new_data_flag | output | 1 | Sticky swap indicator |

## Verification
The swap occurs at the edge where `acq_seq_done` is sampled with full coverage. The published bank, `new_data_pulse` and `new_data_flag` all change at that same edge, so they are due one cycle after the stimulus. `rd_data` is due one edge after `rd_en`. A read aimed at freshly swapped data therefore has to be issued in the cycle after the swap, and it is due one cycle after that. The bench drives every input on the falling edge. It then waits one rising edge and compares the outputs on the following falling edge. Each expected value in the table is written for that one-cycle latency.

// File: rtl/adc_dbuf_pkg.sv
package adc_dbuf_pkg;
  localparam int ADC_SAMPLE_W = 16;
  localparam int ADC_MAX_CH   = 8;
endpackage

// File: rtl/adc_shadow_bank.sv
module adc_shadow_bank #(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  logic [IDX_W-1:0]           wr_ch,
  input  logic [SAMPLE_W-1:0]        wr_data,
  input  logic [NUM_CH-1:0]          en_mask,
  input  logic                       swap_fire,
  output logic [NUM_CH*SAMPLE_W-1:0] shadow_next_flat,
  output logic [NUM_CH-1:0]          cap_next,
  output logic [NUM_CH-1:0]          wr_hit
);
  function automatic logic [NUM_CH-1:0] decode_hit(input logic v, input logic [IDX_W-1:0] ch);
    logic [NUM_CH-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (v && (ch == IDX_W'(i))) r[i] = 1'b1;
    return r;
  endfunction

  logic [NUM_CH-1:0] cap_q;

  assign wr_hit   = decode_hit(wr_valid, wr_ch);
  assign cap_next = cap_q | (wr_hit & en_mask);

  always_ff @(posedge clk) begin
    if (!rst_n)         cap_q <= '0;
    else if (swap_fire) cap_q <= '0;
    else                cap_q <= cap_next;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [SAMPLE_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)         slot_q <= '0;
      else if (wr_hit[g]) slot_q <= wr_data;
    end
    assign shadow_next_flat[g*SAMPLE_W +: SAMPLE_W] = wr_hit[g] ? wr_data : slot_q;
  end
endmodule

// File: rtl/adc_swap_ctrl.sv
module adc_swap_ctrl #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_done,
  input  logic [NUM_CH-1:0] en_mask,
  input  logic [NUM_CH-1:0] cap_next,
  input  logic              ack,
  output logic              seq_covered,
  output logic              swap_fire,
  output logic              new_pulse,
  output logic              new_flag
);
  function automatic logic set_complete(input logic [NUM_CH-1:0] cap, input logic [NUM_CH-1:0] en);
    return (en != '0) && ((cap & en) == en);
  endfunction

  assign seq_covered = set_complete(cap_next, en_mask);
  assign swap_fire   = seq_done && seq_covered;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_pulse <= 1'b0;
      new_flag  <= 1'b0;
    end else begin
      new_pulse <= swap_fire;
      if (swap_fire) new_flag <= 1'b1;
      else if (ack)  new_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_publish_bank.sv
module adc_publish_bank #(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       swap_fire,
  input  logic [NUM_CH-1:0]          en_mask,
  input  logic [NUM_CH*SAMPLE_W-1:0] shadow_next_flat,
  input  logic                       rd_en,
  input  logic [IDX_W-1:0]           rd_ch,
  output logic [SAMPLE_W-1:0]        rd_data,
  output logic [NUM_CH*SAMPLE_W-1:0] pub_flat
);
  function automatic logic [SAMPLE_W-1:0] pick_word(input logic [NUM_CH*SAMPLE_W-1:0] bank,
                                                    input logic [IDX_W-1:0] ch);
    logic [SAMPLE_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ch == IDX_W'(i)) r = bank[i*SAMPLE_W +: SAMPLE_W];
    return r;
  endfunction

  for (genvar g = 0; g < NUM_CH; g++) begin : g_pub
    logic [SAMPLE_W-1:0] pub_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                        pub_q <= '0;
      else if (swap_fire && en_mask[g])  pub_q <= shadow_next_flat[g*SAMPLE_W +: SAMPLE_W];
    end
    assign pub_flat[g*SAMPLE_W +: SAMPLE_W] = pub_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= pick_word(pub_flat, rd_ch);
  end
endmodule

// File: rtl/adc_dbuf_capture.sv
module adc_dbuf_capture
  import adc_dbuf_pkg::*;
#(
  parameter int NUM_CH   = ADC_MAX_CH,
  parameter int SAMPLE_W = ADC_SAMPLE_W,
  localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   ch_en_mask,
  input  logic                acq_valid,
  input  logic [IDX_W-1:0]    acq_ch,
  input  logic [SAMPLE_W-1:0] acq_data,
  input  logic                acq_seq_done,
  input  logic                rd_en,
  input  logic [IDX_W-1:0]    rd_ch,
  output logic [SAMPLE_W-1:0] rd_data,
  input  logic                new_data_ack,
  output logic                new_data_pulse,
  output logic                new_data_flag
);
  logic [NUM_CH*SAMPLE_W-1:0] shadow_next_flat;
  logic [NUM_CH*SAMPLE_W-1:0] pub_flat;
  logic [NUM_CH-1:0]          cap_next;
  logic [NUM_CH-1:0]          wr_hit;
  logic                       seq_covered;
  logic                       swap_fire;

  adc_shadow_bank #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_valid(acq_valid), .wr_ch(acq_ch), .wr_data(acq_data),
    .en_mask(ch_en_mask), .swap_fire(swap_fire), .shadow_next_flat(shadow_next_flat),
    .cap_next(cap_next), .wr_hit(wr_hit));

  adc_swap_ctrl #(.NUM_CH(NUM_CH)) u_swap (
    .clk(clk), .rst_n(rst_n), .seq_done(acq_seq_done), .en_mask(ch_en_mask),
    .cap_next(cap_next), .ack(new_data_ack), .seq_covered(seq_covered),
    .swap_fire(swap_fire), .new_pulse(new_data_pulse), .new_flag(new_data_flag));

  adc_publish_bank #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_pub (
    .clk(clk), .rst_n(rst_n), .swap_fire(swap_fire), .en_mask(ch_en_mask),
    .shadow_next_flat(shadow_next_flat), .rd_en(rd_en), .rd_ch(rd_ch),
    .rd_data(rd_data), .pub_flat(pub_flat));
endmodule

// File: rtl/adc_dbuf_checker.sv
module adc_dbuf_checker #(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       swap_fire,
  input logic                       seq_done,
  input logic                       new_data_pulse,
  input logic                       new_data_flag,
  input logic                       new_data_ack,
  input logic                       rd_en,
  input logic [SAMPLE_W-1:0]        rd_data,
  input logic [NUM_CH-1:0]          ch_en_mask,
  input logic [NUM_CH*SAMPLE_W-1:0] pub_flat
);
  // R3
  swap_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fire |-> seq_done);
  // R8
  pulse_follows_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fire |=> new_data_pulse);
  // R8
  pulse_only_after_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_fire |=> !new_data_pulse);
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (new_data_flag && !new_data_ack) |=> new_data_flag);
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (new_data_ack && !swap_fire) |=> !new_data_flag);
  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R2
  pub_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_fire |=> $stable(pub_flat));
  for (genvar g = 0; g < NUM_CH; g++) begin : g_dis
    // R5
    disabled_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en_mask[g] |=> $stable(pub_flat[g*SAMPLE_W +: SAMPLE_W]));
  end
endmodule

bind adc_dbuf_capture adc_dbuf_checker #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .swap_fire(swap_fire), .seq_done(acq_seq_done),
  .new_data_pulse(new_data_pulse), .new_data_flag(new_data_flag),
  .new_data_ack(new_data_ack), .rd_en(rd_en), .rd_data(rd_data),
  .ch_en_mask(ch_en_mask), .pub_flat(pub_flat));

// File: tb/test_adc_dbuf_capture.sv
module test_adc_dbuf_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ch_en_mask = 8'h0F;
  logic        acq_valid = 1'b0;
  logic [2:0]  acq_ch = '0;
  logic [15:0] acq_data = '0;
  logic        acq_seq_done = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_ch = '0;
  logic [15:0] rd_data;
  logic        new_data_ack = 1'b0;
  logic        new_data_pulse;
  logic        new_data_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_dbuf_capture i_adc_dbuf_capture (
    .clk(clk), .rst_n(rst_n), .ch_en_mask(ch_en_mask), .acq_valid(acq_valid),
    .acq_ch(acq_ch), .acq_data(acq_data), .acq_seq_done(acq_seq_done),
    .rd_en(rd_en), .rd_ch(rd_ch), .rd_data(rd_data), .new_data_ack(new_data_ack),
    .new_data_pulse(new_data_pulse), .new_data_flag(new_data_flag));

  // {valid, ch, data, done, rd, rdch, chk, expected}
  localparam int NV = 18;
  localparam logic [41:0] VEC [NV] = '{
    {1'b1,3'd0,16'hA000,1'b0,1'b1,3'd0,1'b1,16'h0000}, // R2
    {1'b1,3'd1,16'hA001,1'b0,1'b0,3'd0,1'b0,16'h0000},
    {1'b1,3'd2,16'hA002,1'b1,1'b1,3'd1,1'b1,16'h0000}, // R3 early done ignored
    {1'b1,3'd3,16'hA003,1'b0,1'b1,3'd2,1'b1,16'h0000}, // R2
    {1'b0,3'd0,16'h0000,1'b1,1'b1,3'd0,1'b1,16'h0000}, // R7 read with swap
    {1'b0,3'd0,16'h0000,1'b0,1'b1,3'd0,1'b1,16'hA000}, // R4
    {1'b0,3'd0,16'h0000,1'b0,1'b1,3'd3,1'b1,16'hA003}, // R4
    {1'b1,3'd0,16'hB000,1'b0,1'b1,3'd1,1'b1,16'hA001}, // R2
    {1'b1,3'd0,16'hB100,1'b1,1'b1,3'd0,1'b1,16'hA000}, // R10 coverage restarted
    {1'b1,3'd5,16'hC005,1'b0,1'b1,3'd0,1'b1,16'hA000}, // R5 disabled write
    {1'b1,3'd1,16'hB001,1'b0,1'b0,3'd0,1'b0,16'h0000},
    {1'b1,3'd2,16'hB002,1'b0,1'b0,3'd0,1'b0,16'h0000},
    {1'b1,3'd3,16'hB003,1'b1,1'b1,3'd3,1'b1,16'hA003}, // R7, R3 same-cycle write
    {1'b0,3'd0,16'h0000,1'b0,1'b1,3'd0,1'b1,16'hB100}, // R4 newest wins
    {1'b0,3'd0,16'h0000,1'b0,1'b1,3'd3,1'b1,16'hB003}, // R3
    {1'b0,3'd0,16'h0000,1'b0,1'b1,3'd5,1'b1,16'h0000}, // R5 not copied
    {1'b0,3'd0,16'h0000,1'b0,1'b1,3'd2,1'b1,16'hB002}, // R6
    {1'b0,3'd0,16'h0000,1'b0,1'b0,3'd7,1'b1,16'hB002}  // R6 hold
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] ch, input logic [15:0] d,
                      input logic done, input logic rd, input logic [2:0] rch, input logic ack);
    acq_valid = v; acq_ch = ch; acq_data = d; acq_seq_done = done;
    rd_en = rd; rd_ch = rch; new_data_ack = ack;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 rd_data", rd_data, 16'h0);
    check("R1 flag", {15'b0, new_data_flag}, 16'h0);
    check("R1 pulse", {15'b0, new_data_pulse}, 16'h0);
    for (int c = 0; c < 8; c++) begin
      step(1'b0, 3'd0, 16'h0, 1'b0, 1'b1, 3'(c), 1'b0);
      check("R1 published zero", rd_data, 16'h0);
    end

    for (int i = 0; i < NV; i++) begin
      logic [41:0] e;
      e = VEC[i];
      step(e[41], e[40:38], e[37:22], e[21], e[20], e[19:17], 1'b0);
      if (e[16]) check($sformatf("R2-table row %0d", i), rd_data, e[15:0]);
    end

    // R9 flag set by earlier swaps, cleared by ack
    check("R9 flag held", {15'b0, new_data_flag}, 16'h1);
    step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 3'd0, 1'b1);
    check("R9 ack clears", {15'b0, new_data_flag}, 16'h0);

    // R8 pulse timing with single-channel mask
    ch_en_mask = 8'h01;
    step(1'b1, 3'd0, 16'hD000, 1'b1, 1'b0, 3'd0, 1'b0);
    check("R8 pulse high", {15'b0, new_data_pulse}, 16'h1);
    check("R9 flag set", {15'b0, new_data_flag}, 16'h1);
    step(1'b0, 3'd0, 16'h0, 1'b0, 1'b1, 3'd0, 1'b0);
    check("R8 pulse low", {15'b0, new_data_pulse}, 16'h0);
    check("R3 same-cycle write published", rd_data, 16'hD000);

    // R9 swap wins over ack
    step(1'b1, 3'd0, 16'hD111, 1'b1, 1'b0, 3'd0, 1'b1);
    check("R9 set beats ack", {15'b0, new_data_flag}, 16'h1);
    step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 3'd0, 1'b1);
    check("R9 cleared", {15'b0, new_data_flag}, 16'h0);

    // R5 empty mask never swaps
    ch_en_mask = 8'h00;
    step(1'b1, 3'd0, 16'hE000, 1'b1, 1'b0, 3'd0, 1'b0);
    check("R5 no pulse on empty mask", {15'b0, new_data_pulse}, 16'h0);
    step(1'b0, 3'd0, 16'h0, 1'b0, 1'b1, 3'd0, 1'b0);
    check("R5 no swap on empty mask", rd_data, 16'hD111);
    check("R5 flag stays clear", {15'b0, new_data_flag}, 16'h0);

    finish_run();
  end
endmodule